// File: doc/BRIEF.md
# Transmit Symbol Source Selector

This block chooses the quaternary line symbol that is passed to the transmitter once in every symbol period. A mode field selects one of four things to send: symbols from the channel unit, symbols from the receive detector fed back as a loopback, a constant all-ones stream, or an isolated-pulse test pattern. A separate enable sends the chosen data through a self-synchronizing scrambler before it reaches the output.

Each symbol input has its own strobe. A strobe loads a holding register, so a symbol that arrives partway through a period is kept until the next symbol slot. The symbol-rate enable marks each slot. The output symbol, its zero-level flag and its valid flag change only in the cycle after a slot. A mode change made between two slots therefore has no effect until the next slot, and a symbol is never cut short.

Top module: `tx_sym_select`

## Requirements
- R1: `src_sel` selects the source at each slot: 00 is the external symbol, 01 is the looped-back detector symbol, 10 is the constant all-ones stream and 11 is isolated-pulse mode.
- R2: A symbol is coded as {sign, magnitude}: 10 is +3, 11 is +1, 01 is -1 and 00 is -3. With scrambling off, the all-ones source therefore sends 11 (+1) in every slot.
- R3: A strobe loads its symbol into a holding register. A slot uses the held value. If a strobe arrives in the same cycle as the slot, its new value is used.
- R4: With `scr_on` high and a data source selected, the two bits of the symbol pass through the scrambler as a serial stream, sign bit first. Each output bit is the input bit XOR the scrambler outputs sent 5 and 23 bits earlier, and that output bit is shifted into a 23-stage register that starts at zero after reset.
- R5: With `scr_on` low, or in isolated-pulse mode, the selected symbol is output unchanged and the scrambler register keeps its contents.
- R6: In isolated-pulse mode the block sends one +3 symbol (10) with `tx_zero` low. It then sends `gap_len` zero-level slots, each with `tx_zero` high and `tx_sym` 00, and then repeats. Entering the mode always starts with the +3 symbol.
- R7: `tx_zero` is low after any slot that is not in isolated-pulse mode.
- R8: `tx_sym` and `tx_zero` change only in the cycle after a slot. Changes to the mode, the scrambler enable or a strobe between slots have no effect on the outputs until the next slot.
- R9: `tx_vld` is high exactly in the cycle after `sym_en` was high, whatever the mode.
- R10: During and straight after reset, `tx_sym`, `tx_zero` and `tx_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | Symbol-slot enable, one cycle per symbol period |
| src_sel | input | 2 | Source/mode select |
| scr_on | input | 1 | Scrambler enable |
| gap_len | input | GAP_W | Number of zero-level slots after each test pulse |
| ext_sym | input | 2 | External symbol from the channel unit |
| ext_stb | input | 1 | Load strobe for ext_sym |
| det_sym | input | 2 | Detector symbol for loopback |
| det_stb | input | 1 | Load strobe for det_sym |
| tx_sym | output | 2 | Output symbol {sign, magnitude} |
| tx_zero | output | 1 | Output is a zero-level slot |
| tx_vld | output | 1 | Output updated in the previous slot |

## Verification
The assertions assume that `sym_en` is a single-cycle pulse and that there is at least one idle cycle between two slots, so a stability check always has an idle cycle to look at. The bench keeps to this: each slot is followed by idle cycles, and the mode, scrambler enable and strobes are moved only inside those idle gaps or in the slot cycle itself. Using the `{sign, magnitude}` coding, the bench sweeps every symbol value and every pair of consecutive symbols through the scrambler, and it covers gap lengths 0 to 3 in pulse mode.

// File: rtl/tx_sym_select.sv
module tx_sym_select #(
  parameter int SCR_LEN = 23,
  parameter int TAP_A   = 5,
  parameter int TAP_B   = 23,
  parameter int GAP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_en,
  input  logic [1:0]       src_sel,
  input  logic             scr_on,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [1:0]       ext_sym,
  input  logic             ext_stb,
  input  logic [1:0]       det_sym,
  input  logic             det_stb,
  output logic [1:0]       tx_sym,
  output logic             tx_zero,
  output logic             tx_vld
);
  localparam logic [1:0] SRC_EXT   = 2'b00;
  localparam logic [1:0] SRC_DET   = 2'b01;
  localparam logic [1:0] SRC_ONES  = 2'b10;
  localparam logic [1:0] SRC_PULSE = 2'b11;
  localparam logic [1:0] SYM_P3    = 2'b10;
  localparam logic [1:0] SYM_ZERO  = 2'b00;

  logic [1:0]         ext_q, det_q, ext_cur, det_cur, raw;
  logic [SCR_LEN-1:0] sr, sr_mid, sr_nxt;
  logic               s_hi, s_lo, pulse, scr_use;
  logic [GAP_W-1:0]   gap_cnt;

  assign ext_cur = ext_stb ? ext_sym : ext_q;
  assign det_cur = det_stb ? det_sym : det_q;
  assign pulse   = (src_sel == SRC_PULSE);
  assign scr_use = scr_on && !pulse;

  always_comb begin
    case (src_sel)
      SRC_EXT:  raw = ext_cur;
      SRC_DET:  raw = det_cur;
      SRC_ONES: raw = 2'b11;
      default:  raw = SYM_ZERO;
    endcase
  end

  assign s_hi   = raw[1] ^ sr[TAP_A-1] ^ sr[TAP_B-1];
  assign sr_mid = {sr[SCR_LEN-2:0], s_hi};
  assign s_lo   = raw[0] ^ sr_mid[TAP_A-1] ^ sr_mid[TAP_B-1];
  assign sr_nxt = {sr_mid[SCR_LEN-2:0], s_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q   <= '0;
      det_q   <= '0;
      sr      <= '0;
      gap_cnt <= '0;
      tx_sym  <= '0;
      tx_zero <= 1'b0;
      tx_vld  <= 1'b0;
    end else begin
      tx_vld <= sym_en;
      if (ext_stb) ext_q <= ext_sym;
      if (det_stb) det_q <= det_sym;
      if (sym_en) begin
        if (pulse) begin
          if (gap_cnt == '0) begin
            tx_sym  <= SYM_P3;
            tx_zero <= 1'b0;
            gap_cnt <= gap_len;
          end else begin
            tx_sym  <= SYM_ZERO;
            tx_zero <= 1'b1;
            gap_cnt <= gap_cnt - 1'b1;
          end
        end else begin
          gap_cnt <= '0;
          tx_zero <= 1'b0;
          tx_sym  <= scr_use ? {s_hi, s_lo} : raw;
          if (scr_use) sr <= sr_nxt;
        end
      end
    end
  end
endmodule

module tx_sym_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_en,
  input logic [1:0] src_sel,
  input logic       scr_on,
  input logic [1:0] ext_sym,
  input logic       ext_stb,
  input logic [1:0] tx_sym,
  input logic       tx_zero,
  input logic       tx_vld
);
  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_en |=> tx_vld);
  // R9
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> !tx_vld);
  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> ($stable(tx_sym) && $stable(tx_zero)));
  // R6
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zero |-> (tx_sym == 2'b00));
  // R7
  no_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && src_sel != 2'b11) |=> !tx_zero);
  // R2
  ones_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && src_sel == 2'b10 && !scr_on) |=> (tx_sym == 2'b11));
  // R3
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && src_sel == 2'b00 && !scr_on && ext_stb) |=> (tx_sym == $past(ext_sym)));
endmodule

bind tx_sym_select tx_sym_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .src_sel(src_sel),
  .scr_on(scr_on), .ext_sym(ext_sym), .ext_stb(ext_stb),
  .tx_sym(tx_sym), .tx_zero(tx_zero), .tx_vld(tx_vld)
);

// File: tb/tx_sym_select_tb.sv
module tx_sym_select_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_en = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic       scr_on = 1'b0;
  logic [7:0] gap_len = 8'd0;
  logic [1:0] ext_sym = 2'b00;
  logic       ext_stb = 1'b0;
  logic [1:0] det_sym = 2'b00;
  logic       det_stb = 1'b0;
  logic [1:0] tx_sym;
  logic       tx_zero, tx_vld;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [22:0] sr_m = '0;
  logic [1:0]  ext_m = 2'b00, det_m = 2'b00;
  int          cnt_m = 0;

  tx_sym_select u_dut (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .src_sel(src_sel), .scr_on(scr_on),
    .gap_len(gap_len), .ext_sym(ext_sym), .ext_stb(ext_stb), .det_sym(det_sym),
    .det_stb(det_stb), .tx_sym(tx_sym), .tx_zero(tx_zero), .tx_vld(tx_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic scr_bit(input logic b);
    logic o;
    o = b ^ sr_m[4] ^ sr_m[22];
    sr_m = {sr_m[21:0], o};
    return o;
  endfunction

  task automatic slot(input logic [1:0] s, input logic sc, input logic [1:0] e, input logic es,
                      input logic [1:0] d, input logic ds, input int g, input string req);
    logic [1:0] raw, exp_sym;
    logic       exp_z;
    @(negedge clk);
    src_sel = s; scr_on = sc; ext_sym = e; ext_stb = es; det_sym = d; det_stb = ds;
    gap_len = 8'(g); sym_en = 1'b1;
    if (es) ext_m = e;
    if (ds) det_m = d;
    exp_z = 1'b0;
    if (s == 2'b11) begin
      if (cnt_m == 0) begin exp_sym = 2'b10; cnt_m = g; end
      else begin exp_sym = 2'b00; exp_z = 1'b1; cnt_m--; end
    end else begin
      cnt_m = 0;
      raw = (s == 2'b00) ? ext_m : (s == 2'b01) ? det_m : 2'b11;
      if (sc) begin
        exp_sym[1] = scr_bit(raw[1]);
        exp_sym[0] = scr_bit(raw[0]);
      end else exp_sym = raw;
    end
    @(negedge clk);
    sym_en = 1'b0; ext_stb = 1'b0; det_stb = 1'b0;
    check({req, " R9 vld"}, int'(tx_vld), 1);
    check({req, " sym"}, int'(tx_sym), int'(exp_sym));
    check({req, " zero"}, int'(tx_zero), int'(exp_z));
    @(negedge clk);
    check("R9 idle vld", int'(tx_vld), 0);
    check("R8 hold sym", int'(tx_sym), int'(exp_sym));
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", MAX_CYCLES, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 sym", int'(tx_sym), 0);
    check("R10 zero", int'(tx_zero), 0);
    check("R10 vld", int'(tx_vld), 0);
    sym_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1; sym_en = 1'b0;
    @(negedge clk);
    check("R10 after reset vld", int'(tx_vld), 0);

    for (int v = 0; v < 4; v++) slot(2'b00, 0, 2'(v), 1, 2'b00, 0, 0, "R1 R2 ext");
    slot(2'b00, 0, 2'b01, 0, 2'b00, 0, 0, "R3 ext hold");
    for (int v = 0; v < 4; v++) slot(2'b01, 0, 2'b00, 0, 2'(3 - v), 1, 0, "R1 det");
    slot(2'b01, 0, 2'b11, 1, 2'b10, 0, 0, "R3 det hold");
    slot(2'b10, 0, 2'b00, 0, 2'b00, 0, 0, "R2 ones");

    // R3: strobe between slots, then slot without strobe
    @(negedge clk);
    ext_sym = 2'b10; ext_stb = 1'b1; ext_m = 2'b10;
    @(negedge clk);
    ext_stb = 1'b0;
    check("R8 strobe no effect", int'(tx_sym), 2'b11);
    slot(2'b00, 0, 2'b01, 0, 2'b00, 0, 0, "R3 mid-period strobe");

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        slot(2'b00, 1, 2'(a), 1, 2'b00, 0, 0, "R4 scr ext a");
        slot(2'b00, 1, 2'(b), 1, 2'b00, 0, 0, "R4 scr ext b");
      end
    for (int i = 0; i < 8; i++) slot(2'b01, 1, 2'b00, 0, 2'(i), 1, 0, "R4 scr det");
    for (int i = 0; i < 30; i++) slot(2'b10, 1, 2'b00, 0, 2'b00, 0, 0, "R4 scr ones");
    slot(2'b00, 0, 2'b01, 1, 2'b00, 0, 0, "R5 scr off");
    slot(2'b10, 0, 2'b00, 0, 2'b00, 0, 0, "R5 scr off ones");
    slot(2'b11, 1, 2'b00, 0, 2'b00, 0, 1, "R5 pulse scr");
    for (int i = 0; i < 6; i++) slot(2'b00, 1, 2'(i), 1, 2'b00, 0, 0, "R5 scr resume");

    for (int g = 0; g < 4; g++) begin
      slot(2'b00, 0, 2'b01, 1, 2'b00, 0, 0, "R7 data");
      for (int k = 0; k < 2 * (g + 1) + 1; k++)
        slot(2'b11, 0, 2'b00, 0, 2'b00, 0, g, "R6 pulse");
    end
    slot(2'b11, 0, 2'b00, 0, 2'b00, 0, 3, "R6 pulse");
    slot(2'b11, 0, 2'b00, 0, 2'b00, 0, 3, "R6 gap");

    // R8: mode changes between slots leave the output alone
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      src_sel = 2'(m); scr_on = m[0];
      @(negedge clk);
      check("R8 mode change sym", int'(tx_sym), 0);
      check("R8 mode change zero", int'(tx_zero), 1);
      check("R9 mode change vld", int'(tx_vld), 0);
    end
    slot(2'b10, 0, 2'b00, 0, 2'b00, 0, 0, "R7 leave pulse");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule